// File: doc/BRIEF.md
# Vertical Sync and Field Detector

This block takes an already sliced, active-low composite sync bit, sampled on the system clock, and derives two signals from it for interlaced video. The first is an active-low vertical sync pulse whose falling edge marks where the vertical interval begins. The second is a field flag that tells odd fields from even ones. Each sync pulse is classified by how long the input stays low and by how far its falling edge lies from the one before. A wide low pulse is a serration. A falling edge less than three quarters of a line after the previous one is a half-line edge. Any other falling edge ends a full line.

The pulse fires on the trailing edge of the first serration that follows a run of half-line pulses. If the input stays low for too long, a timeout forces the pulse instead. The pulse has a fixed length and is followed by a guard time. While the pulse or the guard time is running, no new trigger is accepted.

The field flag comes from a toggle bit. A full-line edge clears it and each half-line edge flips it. Its value is copied to the output when the vertical pulse starts. Every timing constant is a parameter given in clock cycles, so the same RTL can be set up for different line rates.

The control state machine has four states:
- **ST_LINE**: normal lines.
- **ST_EQUAL**: a half-line run has been seen.
- **ST_VPULSE**: the vertical pulse is active.
- **ST_GUARD**: the guard time after the pulse.

Its transitions are:
- ST_LINE to ST_EQUAL on a half-line edge.
- ST_EQUAL back to ST_LINE on a full-line edge.
- ST_EQUAL to ST_VPULSE on a serration trailing edge.
- ST_LINE or ST_EQUAL to ST_VPULSE on a timeout.
- ST_VPULSE to ST_GUARD when the pulse length has elapsed.
- ST_GUARD to ST_LINE when the guard time has elapsed.

Top module: `vsync_field_detector`

## Requirements
- R1: While `rst` is high at a clock edge, the block drives `vsync_n` to 1 and `field_odd` to 0, and clears all of its counters.
- R2: The input passes through two synchronizer flops. A pulse counts as a serration only when its low width in cycles is strictly greater than LINE_CYC/4. At the default LINE_CYC = 128, a 32-cycle low pulse does not qualify and a 33-cycle low pulse does.
- R3: In ST_EQUAL, the rising input edge of a serration makes `vsync_n` go low after the third clock edge that samples the high input level.
- R4: A serration that arrives while the block is in ST_LINE, with no half-line edge since the last full line, does not produce a vertical pulse.
- R5: If the input is first sampled low at edge k and stays low, the block enters ST_VPULSE at edge k+TIMEOUT_CYC+2, in ST_LINE or ST_EQUAL.
- R6: `vsync_n` stays low for exactly VPULSE_CYC cycles, whether a serration or a timeout started the pulse.
- R7: During ST_VPULSE, and for HOLDOFF_CYC cycles after it ends, serrations and timeouts are ignored.
- R8: A falling-edge spacing below (3*LINE_CYC)/4 cycles is a half-line edge and flips the toggle bit. Any other spacing clears it. At the start of a pulse, `field_odd` takes the toggle value, which is 1 when the number of half-line edges since the last full-line edge is odd.
- R9: `field_odd` changes only on the clock edge where `vsync_n` falls.
- R10: A full-line edge returns the block from ST_EQUAL to ST_LINE, so a serration that follows it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Sliced composite sync, active low, asynchronous to clk |
| vsync_n | output | 1 | Vertical sync pulse, active low |
| field_odd | output | 1 | Field flag: 1 for an odd field, 0 for an even field |

## Verification
The bench drives several input patterns:
- **Full lines only**: shows the block stays quiet on ordinary lines.
- **Two vertical intervals with equalizing runs of different lengths**: opposite toggle parities separate the two field values and check where the trigger lands.
- **A pair of half-line pulses 32 and 33 cycles wide**: locates the serration threshold to within one cycle.
- **Wide pulses on full-line spacing, with and without an earlier half-line run**: confirm that only a half-line run arms the trigger.
- **A long low level on normal lines**: exercises the timeout.
- **Serrations and a long low level sent just after a pulse**: confirm the guard time blocks retriggering.

// File: rtl/vsfd_pkg.sv
package vsfd_pkg;

    typedef enum logic [1:0] {
        ST_LINE,
        ST_EQUAL,
        ST_VPULSE,
        ST_GUARD
    } vstate_e;

    typedef struct packed {
        logic fall;
        logic fall_half;
        logic rise;
        logic rise_broad;
        logic tout;
    } pulse_ev_t;

endpackage

// File: rtl/vsfd_sync_edge.sv
module vsfd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_n_in,
    output logic lvl,
    output logic fall,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], sync_n_in};
    end

    assign lvl  = sh[STAGES-1];
    assign fall = sh[STAGES] & ~sh[STAGES-1];
    assign rise = ~sh[STAGES] & sh[STAGES-1];
endmodule

// File: rtl/vsfd_pulse_class.sv
module vsfd_pulse_class
    import vsfd_pkg::*;
#(
    parameter int LINE_CYC    = 128,
    parameter int TIMEOUT_CYC = 124
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    input  logic      fall,
    input  logic      rise,
    output pulse_ev_t ev
);
    localparam int BROAD_LIM = LINE_CYC / 4;
    localparam int HALF_LIM  = (3 * LINE_CYC) / 4;
    localparam int SPAN      = (LINE_CYC > TIMEOUT_CYC) ? LINE_CYC : TIMEOUT_CYC;
    localparam int CW        = $clog2(SPAN + 1) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] low_cnt;  // low cycles of the current/last pulse
    logic [CW-1:0] gap_cnt;  // cycles since the last falling edge

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            gap_cnt <= CMAX;
        end else begin
            if (fall)
                low_cnt <= CW'(1);
            else if (!lvl && low_cnt != CMAX)
                low_cnt <= low_cnt + CW'(1);

            if (fall)
                gap_cnt <= CW'(1);
            else if (gap_cnt != CMAX)
                gap_cnt <= gap_cnt + CW'(1);
        end
    end

    always_comb begin
        ev.fall       = fall;
        ev.fall_half  = fall && (gap_cnt < CW'(HALF_LIM));
        ev.rise       = rise;
        ev.rise_broad = rise && (low_cnt > CW'(BROAD_LIM));
        ev.tout       = !lvl && !fall && (low_cnt == CW'(TIMEOUT_CYC));
    end
endmodule

// File: rtl/vsfd_field_tff.sv
module vsfd_field_tff (
    input  logic clk,
    input  logic rst,
    input  logic ev_fall,
    input  logic ev_half,
    output logic tff
);
    always_ff @(posedge clk) begin
        if (rst)
            tff <= 1'b0;
        else if (ev_fall)
            tff <= ev_half ? ~tff : 1'b0;
    end
endmodule

// File: rtl/vsync_field_detector.sv
module vsync_field_detector
    import vsfd_pkg::*;
#(
    parameter int LINE_CYC    = 128,
    parameter int TIMEOUT_CYC = 124,
    parameter int VPULSE_CYC  = 464,
    parameter int HOLDOFF_CYC = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_n,
    output logic vsync_n,
    output logic field_odd
);
    localparam int TSPAN = (VPULSE_CYC > HOLDOFF_CYC) ? VPULSE_CYC : HOLDOFF_CYC;
    localparam int TW    = $clog2(TSPAN + 1);

    logic      s_lvl, s_fall, s_rise;
    pulse_ev_t ev;
    logic      tff;

    vsfd_sync_edge #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sync_n_in (sync_n),
        .lvl       (s_lvl),
        .fall      (s_fall),
        .rise      (s_rise)
    );

    vsfd_pulse_class #(.LINE_CYC(LINE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_class (
        .clk  (clk),
        .rst  (rst),
        .lvl  (s_lvl),
        .fall (s_fall),
        .rise (s_rise),
        .ev   (ev)
    );

    vsfd_field_tff u_tff (
        .clk     (clk),
        .rst     (rst),
        .ev_fall (ev.fall),
        .ev_half (ev.fall_half),
        .tff     (tff)
    );

    vstate_e       state, state_nx;
    logic [TW-1:0] tmr;

    // state register and phase timer
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LINE;
            tmr   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state || state == ST_LINE || state == ST_EQUAL)
                tmr <= '0;
            else
                tmr <= tmr + TW'(1);
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LINE: begin
                if (ev.tout)           state_nx = ST_VPULSE;
                else if (ev.fall_half) state_nx = ST_EQUAL;
            end
            ST_EQUAL: begin
                if (ev.tout || ev.rise_broad)      state_nx = ST_VPULSE;
                else if (ev.fall && !ev.fall_half) state_nx = ST_LINE;
            end
            ST_VPULSE: begin
                if (tmr == TW'(VPULSE_CYC - 1)) state_nx = ST_GUARD;
            end
            ST_GUARD: begin
                if (tmr == TW'(HOLDOFF_CYC - 1)) state_nx = ST_LINE;
            end
            default: state_nx = ST_LINE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            vsync_n   <= 1'b1;
            field_odd <= 1'b0;
        end else begin
            vsync_n <= (state_nx != ST_VPULSE);
            if (state_nx == ST_VPULSE && state != ST_VPULSE)
                field_odd <= tff;
        end
    end
endmodule

// File: rtl/vsync_field_detector_chk.sv
module vsync_field_detector_chk #(
    parameter int VPULSE_CYC  = 464,
    parameter int HOLDOFF_CYC = 512
) (
    input logic clk,
    input logic rst,
    input logic vsync_n,
    input logic field_odd
);
    localparam int LW = $clog2(VPULSE_CYC + 2) + 1;
    localparam int HW = $clog2(HOLDOFF_CYC + 2);

    logic [LW-1:0] lowcnt;
    logic [HW-1:0] hicnt;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            lowcnt <= '0;
            hicnt  <= '0;
            seen   <= 1'b0;
        end else begin
            lowcnt <= vsync_n ? '0 : lowcnt + LW'(1);
            if (!vsync_n)
                hicnt <= '0;
            else if (hicnt != HW'(HOLDOFF_CYC))
                hicnt <= hicnt + HW'(1);
            seen <= seen | !vsync_n;
        end
    end

    // R6: pulse ends after exactly VPULSE_CYC low cycles
    p_width_exact_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_n) |-> (lowcnt == LW'(VPULSE_CYC)));

    // R6: pulse never runs longer
    p_width_max_r6: assert property (@(posedge clk) disable iff (rst)
        !vsync_n |-> (lowcnt < LW'(VPULSE_CYC)));

    // R7: no new pulse inside the guard window
    p_holdoff_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(vsync_n) && seen) |-> (hicnt >= HW'(HOLDOFF_CYC)));

    // R9: field flag only moves when the pulse starts
    p_field_at_start_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_odd) |-> $fell(vsync_n));
endmodule

bind vsync_field_detector vsync_field_detector_chk #(
    .VPULSE_CYC  (VPULSE_CYC),
    .HOLDOFF_CYC (HOLDOFF_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vsync_n   (vsync_n),
    .field_odd (field_odd)
);

// File: tb/test_vsync_field_detector.sv
module test_vsync_field_detector;
    localparam int LINE  = 128;
    localparam int TOUT  = 124;
    localparam int VP    = 464;
    localparam int HO    = 512;
    localparam int HALFL = (3 * LINE) / 4;
    localparam int HALF  = LINE / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_n = 1'b1;
    logic vsync_n, field_odd;

    always #4 clk = ~clk;  // 125 MHz

    vsync_field_detector #(
        .LINE_CYC(LINE), .TIMEOUT_CYC(TOUT), .VPULSE_CYC(VP), .HOLDOFF_CYC(HO)
    ) i_vsync_field_detector (
        .clk(clk), .rst(rst), .sync_n(sync_n), .vsync_n(vsync_n), .field_odd(field_odd)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nfalls = 0;
    bit done   = 1'b0;

    int    q_cyc[$];
    bit    q_fld[$];
    string q_tag[$];

    int last_fall = -100000;
    bit par = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic note_fall();
        if (cyc - last_fall < HALFL) par = ~par;
        else                         par = 1'b0;
        last_fall = cyc;
    endtask

    // one pulse: low for low_w cycles, period per; trig pushes an expected serration trigger
    task automatic pulse(input int low_w, input int per, input bit trig, input string tag);
        note_fall();
        sync_n = 1'b0;
        repeat (low_w) @(negedge clk);
        if (trig) begin
            q_cyc.push_back(cyc + 3);
            q_fld.push_back(par);
            q_tag.push_back(tag);
        end
        sync_n = 1'b1;
        repeat (per - low_w) @(negedge clk);
    endtask

    // long low level expected to trip the timeout
    task automatic long_low(input int low_w, input int per, input bit trig, input string tag);
        note_fall();
        if (trig) begin
            q_cyc.push_back(cyc + TOUT + 3);
            q_fld.push_back(par);
            q_tag.push_back(tag);
        end
        sync_n = 1'b0;
        repeat (low_w) @(negedge clk);
        sync_n = 1'b1;
        repeat (per - low_w) @(negedge clk);
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) pulse(9, LINE, 1'b0, "");
    endtask

    task automatic eqs(input int n);
        for (int i = 0; i < n; i++) pulse(5, HALF, 1'b0, "");
    endtask

    // monitor side of the scoreboard
    bit prev_vs = 1'b1;
    bit prev_fd = 1'b0;
    int lowrun  = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_vs && !vsync_n) begin
                nfalls++;
                lowrun = 1;
                if (q_cyc.size() == 0) begin
                    check("R7 unexpected vertical pulse", 1, 0);
                end else begin
                    automatic int    ec = q_cyc.pop_front();
                    automatic bit    ef = q_fld.pop_front();
                    automatic string et = q_tag.pop_front();
                    check({et, " pulse start cycle"}, cyc, ec);
                    check("R8 field value at pulse start", int'(field_odd), int'(ef));
                end
            end else if (!vsync_n) begin
                lowrun++;
            end
            if (!prev_vs && vsync_n) check("R6 pulse width", lowrun, VP);
            if (field_odd != prev_fd)
                check("R9 field change outside pulse start", int'(prev_vs && !vsync_n), 1);
            prev_vs = vsync_n;
            prev_fd = field_odd;
        end
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check("R1 vsync_n in reset", int'(vsync_n), 1);
        check("R1 field_odd in reset", int'(field_odd), 0);
        rst = 1'b0;
        @(negedge clk);

        // ordinary lines only
        base = nfalls;
        lines(8);
        check("R4 no pulse on normal lines", nfalls - base, 0);

        // interval with 5 equalizing pulses, then serrations (R3)
        eqs(5);
        pulse(54, HALF, 1'b1, "R3");
        for (int i = 0; i < 5; i++) pulse(54, HALF, 1'b0, "");
        eqs(6);
        long_low(200, 256, 1'b0, "");  // timeout inside the guard window (R7)
        lines(8);

        // interval with 4 equalizing pulses: opposite parity
        eqs(4);
        pulse(54, HALF, 1'b1, "R3");
        for (int i = 0; i < 5; i++) pulse(54, HALF, 1'b0, "");
        eqs(6);
        lines(10);

        // serration threshold: 32 not broad, 33 broad (R2)
        eqs(4);
        pulse(32, HALF, 1'b0, "");
        pulse(33, HALF, 1'b1, "R2");
        eqs(6);
        lines(10);

        // wide pulses on full-line spacing with no half-line run (R4)
        base = nfalls;
        pulse(60, LINE, 1'b0, "");
        pulse(60, LINE, 1'b0, "");
        lines(2);
        check("R4 serration in ST_LINE ignored", nfalls - base, 0);

        // half-line run broken by a full line, then a serration (R10)
        base = nfalls;
        eqs(3);
        pulse(5, LINE, 1'b0, "");
        pulse(54, HALF, 1'b0, "");
        lines(4);
        check("R10 full line disarms trigger", nfalls - base, 0);

        // timeout path (R5)
        lines(2);
        pulse(9, HALF, 1'b0, "");
        long_low(200, 384, 1'b1, "R5");
        lines(10);

        repeat (20) @(negedge clk);
        check("R3 all expected pulses seen", q_cyc.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule